// File: doc/BRIEF.md
# NAND Controller Event and ECC Status Unit

This unit gathers the event and error-correction results produced by a NAND flash controller core and presents them to a host in two forms. The live status register shows the present state: the ready levels of the flash device, the controller and the ECC engine, plus the result of the most recent page-chunk decode (uncorrectable failure, errors found, and how many symbols were corrected). The interrupt status register latches events as they occur and holds them until the host reads that register, and the read itself clears them.

A mask register, using the same bit layout as the interrupt status, chooses which latched events drive the level-high interrupt line. The host reaches the three registers through a simple single-cycle read/write strobe interface. Read data is registered and appears in the cycle after the read strobe.

Top module: `nand_evt_status`

## Requirements
- R1: After reset all latched flags, the mask, the live decode fields and `rdData` are zero and `irqOut` is low.
- R2: Latched flag bit positions (address 1): bit 5 flash ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault. Each is set by its event: a rising edge of `nandReady`, `ctrlReady` or `eccReady`, a `decValid` pulse with `decFail` or with `decErr`, or a `wpFault` pulse.
- R3: A read of address 1 returns the flags as they stood before the read, and clears them at that clock edge.
- R4: An event arriving in the same cycle as a clearing read remains latched after that read.
- R5: A write to address 2 stores `wrData[5:0]` as the mask, using the same bit positions as R2; a read of address 2 returns it.
- R6: `irqOut` is high exactly while some latched flag has its mask bit set, and stays high until that flag is cleared or masked.
- R7: Live status (address 0) bits 0, 1, 2 follow `nandReady`, `ctrlReady`, `eccReady` one clock later.
- R8: A `decValid` pulse updates live bit 6 to `decFail`, bit 3 to `decErr`, and bits [5:4] to `corrCnt` minus one (1 to 4 corrected symbols read as 0 to 3).
- R9: Live bits [5:4] read zero whenever live bit 3 is clear.
- R10: A ready input held high sets its flag once; the flag does not return after being cleared while the input stays high.
- R11: A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nandReady | input | 1 | Flash device ready level |
| ctrlReady | input | 1 | Controller ready level |
| eccReady | input | 1 | ECC engine ready level |
| decValid | input | 1 | One-cycle strobe: a decode result is present |
| decErr | input | 1 | Decode found correctable errors |
| decFail | input | 1 | Decode was uncorrectable |
| corrCnt | input | CNT_IN_W (3) | Corrected symbol count, 1 to CORR_MAX |
| wpFault | input | 1 | One-cycle write-protect fault pulse |
| regRead | input | 1 | Host read strobe |
| regWrite | input | 1 | Host write strobe |
| regAddr | input | 2 | Register select: 0 live, 1 interrupt, 2 mask, 3 unused |
| wrData | input | RD_W (8) | Host write data |
| rdData | output | RD_W (8) | Registered host read data |
| irqOut | output | 1 | Active-high level interrupt |

## Verification
On every cycle the assertions check that an event coinciding with a clearing read survives it, that a clearing read with no new event empties the flags, that an asserted interrupt persists until a clear or a mask write, and that the corrected-count field is zero whenever errors-detected is low. What the assertions cannot show is the register map itself: the bit placement of each event, the count-minus-one encoding across all four counts, the one-cycle lag of the live ready bits, the mask gating for every combination of mask and event, and the edge-only setting of held ready levels, which the bench sweeps.

// File: rtl/nand_stat_pkg.sv
package nand_stat_pkg;

  localparam int IRQ_N = 6;

  // interrupt flag / mask bit positions (host-visible)
  localparam int IRQ_WPF   = 0;
  localparam int IRQ_ECC   = 1;
  localparam int IRQ_DERR  = 2;
  localparam int IRQ_DFAIL = 3;
  localparam int IRQ_CRDY  = 4;
  localparam int IRQ_NRDY  = 5;

  // live status bit positions (host-visible)
  localparam int LS_NRDY   = 0;
  localparam int LS_CRDY   = 1;
  localparam int LS_ECC    = 2;
  localparam int LS_ERR    = 3;
  localparam int LS_CNT_LO = 4;
  localparam int LS_FAIL   = 6;

  typedef enum logic [1:0] {
    SEL_LIVE = 2'd0,
    SEL_IRQ  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    clrIrq;
    logic    wrMask;
    logic    ldRd;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/nand_stat_ctrl.sv
module nand_stat_ctrl
  import nand_stat_pkg::*;
(
  input  logic       regRead,
  input  logic       regWrite,
  input  logic [1:0] regAddr,
  output strobe_t    stb
);

  regSel_e addrSel;

  always_comb begin
    addrSel    = regSel_e'(regAddr);
    stb.ldRd   = regRead;
    stb.rdSel  = addrSel;
    stb.clrIrq = regRead && (addrSel == SEL_IRQ);
    stb.wrMask = regWrite && (addrSel == SEL_MASK);
  end

endmodule

// File: rtl/nand_stat_dp.sv
module nand_stat_dp
  import nand_stat_pkg::*;
#(
  parameter int RD_W     = 8,
  parameter int CORR_MAX = 4,
  localparam int CNT_W    = $clog2(CORR_MAX),
  localparam int CNT_IN_W = $clog2(CORR_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic                nandReady,
  input  logic                ctrlReady,
  input  logic                eccReady,
  input  logic                decValid,
  input  logic                decErr,
  input  logic                decFail,
  input  logic [CNT_IN_W-1:0] corrCnt,
  input  logic                wpFault,
  input  logic [RD_W-1:0]     wrData,
  output logic [RD_W-1:0]     rdData,
  output logic                irqOut
);

  logic [2:0]       rdyIn;
  logic [2:0]       rdyQ;
  logic [2:0]       rdyRise;
  logic [IRQ_N-1:0] setVec;
  logic [IRQ_N-1:0] flags;
  logic [IRQ_N-1:0] mask;
  logic             liveErr;
  logic             liveFail;
  logic [CNT_W-1:0] liveCnt;
  logic [RD_W-1:0]  liveWord;
  logic [RD_W-1:0]  rdNext;

  assign rdyIn = {eccReady, ctrlReady, nandReady};

  // one register stage on the ready levels; rise = new high seen this cycle
  always_ff @(posedge clk) begin
    if (!rst_n) rdyQ <= '0;
    else        rdyQ <= rdyIn;
  end

  assign rdyRise = rdyIn & ~rdyQ;

  always_comb begin
    setVec            = '0;
    setVec[IRQ_NRDY]  = rdyRise[0];
    setVec[IRQ_CRDY]  = rdyRise[1];
    setVec[IRQ_ECC]   = rdyRise[2];
    setVec[IRQ_DFAIL] = decValid && decFail;
    setVec[IRQ_DERR]  = decValid && decErr;
    setVec[IRQ_WPF]   = wpFault;
  end

  // per-flag latch: set wins over the clearing read
  for (genvar i = 0; i < IRQ_N; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (setVec[i])  flags[i] <= 1'b1;
      else if (stb.clrIrq) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          mask <= '0;
    else if (stb.wrMask) mask <= wrData[IRQ_N-1:0];
  end

  // last decode result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      liveErr  <= 1'b0;
      liveFail <= 1'b0;
      liveCnt  <= '0;
    end else if (decValid) begin
      liveErr  <= decErr;
      liveFail <= decFail;
      if (decErr) liveCnt <= CNT_W'(corrCnt - CNT_IN_W'(1));
      else        liveCnt <= '0;
    end
  end

  always_comb begin
    liveWord                              = '0;
    liveWord[LS_NRDY]                     = rdyQ[0];
    liveWord[LS_CRDY]                     = rdyQ[1];
    liveWord[LS_ECC]                      = rdyQ[2];
    liveWord[LS_ERR]                      = liveErr;
    liveWord[LS_CNT_LO +: CNT_W]          = liveCnt;
    liveWord[LS_FAIL]                     = liveFail;
  end

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      SEL_LIVE: rdNext = liveWord;
      SEL_IRQ:  rdNext[IRQ_N-1:0] = flags;
      SEL_MASK: rdNext[IRQ_N-1:0] = mask;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rdData <= '0;
    else if (stb.ldRd) rdData <= rdNext;
  end

  assign irqOut = |(flags & mask);

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|setVec) |=> ((flags & $past(setVec)) == $past(setVec))); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrIrq && !(|setVec)) |=> (flags == '0)); // R3

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && !stb.clrIrq && !stb.wrMask) |=> irqOut); // R6

  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !liveWord[LS_ERR] |-> (liveWord[LS_CNT_LO +: CNT_W] == '0)); // R9

endmodule

// File: rtl/nand_evt_status.sv
module nand_evt_status
  import nand_stat_pkg::*;
#(
  parameter int RD_W     = 8,
  parameter int CORR_MAX = 4,
  localparam int CNT_IN_W = $clog2(CORR_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nandReady,
  input  logic                ctrlReady,
  input  logic                eccReady,
  input  logic                decValid,
  input  logic                decErr,
  input  logic                decFail,
  input  logic [CNT_IN_W-1:0] corrCnt,
  input  logic                wpFault,
  input  logic                regRead,
  input  logic                regWrite,
  input  logic [1:0]          regAddr,
  input  logic [RD_W-1:0]     wrData,
  output logic [RD_W-1:0]     rdData,
  output logic                irqOut
);

  strobe_t stb;

  nand_stat_ctrl uCtrl (
    .regRead  (regRead),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .stb      (stb)
  );

  nand_stat_dp #(
    .RD_W     (RD_W),
    .CORR_MAX (CORR_MAX)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .nandReady (nandReady),
    .ctrlReady (ctrlReady),
    .eccReady  (eccReady),
    .decValid  (decValid),
    .decErr    (decErr),
    .decFail   (decFail),
    .corrCnt   (corrCnt),
    .wpFault   (wpFault),
    .wrData    (wrData),
    .rdData    (rdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/nand_evt_status_test.sv
`timescale 1ns/1ps
module nand_evt_status_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nandReady = 0, ctrlReady = 0, eccReady = 0;
  logic       decValid = 0, decErr = 0, decFail = 0, wpFault = 0;
  logic [2:0] corrCnt = 3'd0;
  logic       regRead = 0, regWrite = 0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  nand_evt_status uut (
    .clk(clk), .rst_n(rst_n),
    .nandReady(nandReady), .ctrlReady(ctrlReady), .eccReady(eccReady),
    .decValid(decValid), .decErr(decErr), .decFail(decFail),
    .corrCnt(corrCnt), .wpFault(wpFault),
    .regRead(regRead), .regWrite(regWrite), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    regRead = 1; regAddr = a;
    @(negedge clk);
    regRead = 0;
    v = rdData;
  endtask

  task automatic wrMask(input logic [7:0] m);
    regWrite = 1; regAddr = 2'd2; wrData = m;
    @(negedge clk);
    regWrite = 0;
  endtask

  // one event for flag index i, lasting one clock
  task automatic fire(input int i, input logic [2:0] cnt);
    case (i)
      0: wpFault = 1;
      1: eccReady = 1;
      2: begin decValid = 1; decErr = 1; corrCnt = cnt; end
      3: begin decValid = 1; decFail = 1; corrCnt = cnt; end
      4: ctrlReady = 1;
      default: nandReady = 1;
    endcase
    @(negedge clk);
    wpFault = 0; eccReady = 0; ctrlReady = 0; nandReady = 0;
    decValid = 0; decErr = 0; decFail = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irqOut, 0);
    chk("R1 rdData", rdData, 0);
    rdReg(2'd1, v); chk("R1 flags", v, 0);
    rdReg(2'd2, v); chk("R1 mask", v, 0);
    rdReg(2'd0, v); chk("R1 live", v, 0);

    // R11 unused address
    rdReg(2'd3, v); chk("R11 unused", v, 0);

    // R2 R3 R5 R6 sweep: every mask against every single event
    for (int m = 0; m < 64; m++) begin
      wrMask(8'(m));
      rdReg(2'd2, v); chk("R5 mask readback", v, m);
      for (int i = 0; i < 6; i++) begin
        fire(i, 3'd1);
        chk("R6 irq level", irqOut, (m >> i) & 1);
        @(negedge clk);
        chk("R6 irq held", irqOut, (m >> i) & 1);
        rdReg(2'd1, v); chk("R2 flag position / R3 read value", v, 1 << i);
        chk("R3 irq after clear", irqOut, 0);
        rdReg(2'd1, v); chk("R3 cleared", v, 0);
      end
    end

    // R6 masking a latched flag drops the line
    wrMask(8'h3f);
    fire(0, 3'd1);
    chk("R6 set", irqOut, 1);
    wrMask(8'h3e);
    chk("R6 masked", irqOut, 0);
    rdReg(2'd1, v); chk("R6 flag still latched", v, 8'h01);

    // R4 event in the same cycle as clearing read
    fire(1, 3'd1);
    regRead = 1; regAddr = 2'd1; wpFault = 1;
    @(negedge clk);
    regRead = 0; wpFault = 0;
    chk("R4 read value", rdData, 8'h02);
    rdReg(2'd1, v); chk("R4 kept", v, 8'h01);

    // R8 count encoding, all counts
    for (int c = 1; c <= 4; c++) begin
      fire(2, 3'(c));
      rdReg(2'd0, v);
      chk("R8 live decode err", v, 8'h08 | ((c - 1) << 4));
    end
    // R8 R9 failure without errors flag: count reads zero
    fire(3, 3'd3);
    rdReg(2'd0, v); chk("R9 fail count zero", v, 8'h40);
    // R8 fail together with error
    decValid = 1; decFail = 1; decErr = 1; corrCnt = 3'd4;
    @(negedge clk);
    decValid = 0; decFail = 0; decErr = 0;
    rdReg(2'd0, v); chk("R8 fail and err", v, 8'h78);
    // R9 clean decode clears count
    decValid = 1; corrCnt = 3'd2;
    @(negedge clk);
    decValid = 0;
    rdReg(2'd0, v); chk("R9 clean decode", v, 8'h00);
    rdReg(2'd1, v);

    // R7 ready bits lag one clock
    regRead = 1; regAddr = 2'd0; nandReady = 1; ctrlReady = 1; eccReady = 1;
    @(negedge clk);
    chk("R7 not yet", rdData, 8'h00);
    @(negedge clk);
    chk("R7 follows", rdData, 8'h07);
    nandReady = 0; ctrlReady = 0;
    @(negedge clk);
    chk("R7 still old", rdData, 8'h07);
    @(negedge clk);
    regRead = 0;
    chk("R7 drops", rdData, 8'h04);
    eccReady = 0;

    // R10 held level sets once
    rdReg(2'd1, v);
    nandReady = 1;
    repeat (2) @(negedge clk);
    rdReg(2'd1, v); chk("R10 first rise", v, 8'h20);
    repeat (3) @(negedge clk);
    rdReg(2'd1, v); chk("R10 held no reset", v, 8'h00);
    nandReady = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule